// File: doc/BRIEF.md
# Chirp Trigger Sequencer with Mixer Interlock

This block accepts chirp requests from a controller that runs on a 100 MHz clock. The controller signals a request by flipping a single level. Each flip is detected on the controller clock and carried to the 120 MHz transmit clock through a toggle handshake. On the transmit clock, a sequencer runs a transmit window and then a listen window of fixed lengths.

While the sequence runs, the block drives the RF switch, the transmit and receive mixer enables, four identical T/R select lines, an ADC power-down pin and a chirp-active strobe for the waveform generator. A hardware interlock keeps the two mixers from ever being on together. It also shuts both mixers off soon after the master enable drops. The 6-bit number of chirps started is sent back to the controller clock domain in Gray code.

Top module: `chirp_interlock`

## Requirements
- R1: After reset, rfSwitch, txMixEn, rxMixEn, trSel, chirpActive and adcPwdn are 0, the sequencer is idle, and chirpCount is 0.
- R2: Every change of chirpReq, rising or falling, is one request and starts exactly one chirp sequence. chirpReq is held stable for at least 4 clkCtl cycles.
- R3: txMixEn and rxMixEn are never 1 in the same clkTx cycle.
- R4: Within 12 clkCtl cycles after mixMaster goes low, txMixEn and rxMixEn are both 0. They stay 0 while mixMaster stays low, even though the sequence and rfSwitch keep running.
- R5: A sequence has two windows. The transmit window lasts TX_LEN clkTx cycles, with rfSwitch=1, chirpActive=1, txMixEn=mixMaster and trSel=4'b1111. The listen window then lasts RX_LEN cycles, with rxMixEn=mixMaster and rfSwitch=chirpActive=0 and trSel=4'b0000. After that the block returns to idle with all of these outputs 0.
- R6: All four trSel bits always carry the same value, and adcPwdn is always 0.
- R7: chirpCount, on the clkCtl clock, goes up by one for each sequence started and wraps from 63 to 0.
- R8: A request that arrives while a sequence is running is held as a single pending request and starts the next sequence as soon as the listen window ends. Any further requests during the same sequence are dropped.
- R9: Two requests spaced 500 ns apart both produce a full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkCtl | input | 1 | 100 MHz controller clock |
| clkTx | input | 1 | 120 MHz transmit clock |
| rstN | input | 1 | Asynchronous active-low reset, both domains |
| chirpReq | input | 1 | Request level; each change is one request |
| mixMaster | input | 1 | Master mixer enable (controller domain) |
| rfSwitch | output | 1 | RF switch to transmit path |
| txMixEn | output | 1 | Transmit mixer enable |
| rxMixEn | output | 1 | Receive mixer enable |
| trSel | output | 4 | T/R select lines, all equal |
| adcPwdn | output | 1 | ADC power-down, held low |
| chirpActive | output | 1 | Strobe to the DAC waveform path during transmit |
| chirpCount | output | 6 | Chirps started, in the clkCtl domain |

## Verification
The hardest case to reach from the ports is a request that lands while a sequence is already running, followed by another that must be thrown away. The stimulus flips chirpReq three times, 100 ns apart, well inside one sequence. It then waits for the pipeline to empty and expects the returned count to have grown by two, not three. Two related cases are also driven: a master-enable drop timed to hit the middle of the transmit window, and a long run of requests that carries the Gray-coded count across its wrap point.

// File: rtl/chirp_seq_pkg.sv
package chirp_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_TX     = 2'd1,
    SEQ_LISTEN = 2'd2
  } seqPhase_t;

  // strobes from the sequencer into the datapath
  typedef struct packed {
    logic txOn;
    logic rxOn;
    logic chirpStart;
  } seqStrobe_t;
endpackage

// File: rtl/chirp_seq_ctl.sv
module chirp_seq_ctl
  import chirp_seq_pkg::*;
#(
  parameter int TX_LEN = 1200,
  parameter int RX_LEN = 3000
) (
  input  logic       clkTx,
  input  logic       rstN,
  input  logic       reqPulse,
  output seqStrobe_t strobe
);
  localparam int MAX_LEN = (TX_LEN > RX_LEN) ? TX_LEN : RX_LEN;
  localparam int CW = $clog2(MAX_LEN + 1);
  localparam logic [CW-1:0] TX_LAST = CW'(TX_LEN - 1);
  localparam logic [CW-1:0] RX_LAST = CW'(RX_LEN - 1);

  seqPhase_t phase;
  logic [CW-1:0] winCnt;
  logic pending;
  logic startNow;
  logic listenDone;

  assign listenDone = (phase == SEQ_LISTEN) && (winCnt == RX_LAST);
  assign startNow = ((phase == SEQ_IDLE) && reqPulse) ||
                    (listenDone && (pending || reqPulse));

  always_ff @(posedge clkTx or negedge rstN) begin
    if (!rstN) begin
      phase   <= SEQ_IDLE;
      winCnt  <= '0;
      pending <= 1'b0;
    end else begin
      unique case (phase)
        SEQ_IDLE: begin
          winCnt <= '0;
          if (reqPulse) phase <= SEQ_TX;
        end
        SEQ_TX: begin
          if (reqPulse) pending <= 1'b1;
          if (winCnt == TX_LAST) begin
            phase  <= SEQ_LISTEN;
            winCnt <= '0;
          end else begin
            winCnt <= winCnt + 1'b1;
          end
        end
        SEQ_LISTEN: begin
          if (listenDone) begin
            winCnt  <= '0;
            pending <= 1'b0;
            phase   <= startNow ? SEQ_TX : SEQ_IDLE;
          end else begin
            winCnt <= winCnt + 1'b1;
            if (reqPulse) pending <= 1'b1;
          end
        end
        default: phase <= SEQ_IDLE;
      endcase
    end
  end

  assign strobe.txOn       = (phase == SEQ_TX);
  assign strobe.rxOn       = (phase == SEQ_LISTEN);
  assign strobe.chirpStart = startNow;

  assert_tx_to_listen_R5: assert property (@(posedge clkTx) disable iff (!rstN)
    (phase == SEQ_TX && winCnt == TX_LAST) |=> (phase == SEQ_LISTEN));
  assert_idle_start_R2: assert property (@(posedge clkTx) disable iff (!rstN)
    (phase == SEQ_IDLE && reqPulse) |=> (phase == SEQ_TX));
  assert_pending_busy_R8: assert property (@(posedge clkTx) disable iff (!rstN)
    $rose(pending) |-> (phase != SEQ_IDLE));
endmodule

// File: rtl/chirp_seq_dp.sv
module chirp_seq_dp
  import chirp_seq_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int TR_N  = 4
) (
  input  logic             clkCtl,
  input  logic             clkTx,
  input  logic             rstN,
  input  logic             chirpReq,
  input  logic             mixMaster,
  input  seqStrobe_t       strobe,
  output logic             reqPulse,
  output logic             rfSwitch,
  output logic             txMixEn,
  output logic             rxMixEn,
  output logic [TR_N-1:0]  trSel,
  output logic             adcPwdn,
  output logic             chirpActive,
  output logic [CNT_W-1:0] chirpCount
);
  // controller domain: edge detect and toggle
  logic [2:0] reqMeta;
  logic reqTgl;
  always_ff @(posedge clkCtl or negedge rstN) begin
    if (!rstN) begin
      reqMeta <= '0;
      reqTgl  <= 1'b0;
    end else begin
      reqMeta <= {reqMeta[1:0], chirpReq};
      reqTgl  <= reqTgl ^ (reqMeta[2] ^ reqMeta[1]);
    end
  end

  // transmit domain: toggle sync and enable sync
  logic [2:0] tglSync;
  logic [1:0] enSync;
  always_ff @(posedge clkTx or negedge rstN) begin
    if (!rstN) begin
      tglSync <= '0;
      enSync  <= '0;
    end else begin
      tglSync <= {tglSync[1:0], reqTgl};
      enSync  <= {enSync[0], mixMaster};
    end
  end
  assign reqPulse = tglSync[2] ^ tglSync[1];

  // registered RF outputs with interlock
  always_ff @(posedge clkTx or negedge rstN) begin
    if (!rstN) begin
      rfSwitch    <= 1'b0;
      txMixEn     <= 1'b0;
      rxMixEn     <= 1'b0;
      chirpActive <= 1'b0;
      adcPwdn     <= 1'b0;
    end else begin
      rfSwitch    <= strobe.txOn;
      chirpActive <= strobe.txOn;
      txMixEn     <= strobe.txOn & enSync[1];
      rxMixEn     <= strobe.rxOn & enSync[1] & ~strobe.txOn;
      adcPwdn     <= 1'b0;
    end
  end

  for (genvar g = 0; g < TR_N; g++) begin : gTr
    always_ff @(posedge clkTx or negedge rstN) begin
      if (!rstN) trSel[g] <= 1'b0;
      else       trSel[g] <= strobe.txOn;
    end
  end

  // chirp counter and Gray return path
  logic [CNT_W-1:0] txCount, txCountNext, grayTx;
  assign txCountNext = txCount + CNT_W'(strobe.chirpStart);
  always_ff @(posedge clkTx or negedge rstN) begin
    if (!rstN) begin
      txCount <= '0;
      grayTx  <= '0;
    end else begin
      txCount <= txCountNext;
      grayTx  <= txCountNext ^ (txCountNext >> 1);
    end
  end

  function automatic logic [CNT_W-1:0] grayToBin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [CNT_W-1:0] grayMeta, graySync;
  always_ff @(posedge clkCtl or negedge rstN) begin
    if (!rstN) begin
      grayMeta   <= '0;
      graySync   <= '0;
      chirpCount <= '0;
    end else begin
      grayMeta   <= grayTx;
      graySync   <= grayMeta;
      chirpCount <= grayToBin(graySync);
    end
  end

  assert_mix_excl_R3: assert property (@(posedge clkTx) disable iff (!rstN)
    !(txMixEn && rxMixEn));
  assert_mix_off_R4: assert property (@(posedge clkTx) disable iff (!rstN)
    !enSync[1] |=> (!txMixEn && !rxMixEn));
  assert_gray_step_R7: assert property (@(posedge clkCtl) disable iff (!rstN)
    $countones(graySync ^ $past(graySync)) <= 1);
  assert_tr_follow_R5: assert property (@(posedge clkTx) disable iff (!rstN)
    txMixEn |-> (rfSwitch && chirpActive));
endmodule

// File: rtl/chirp_interlock.sv
module chirp_interlock #(
  parameter int TX_LEN = 1200,
  parameter int RX_LEN = 3000
) (
  input  logic       clkCtl,
  input  logic       clkTx,
  input  logic       rstN,
  input  logic       chirpReq,
  input  logic       mixMaster,
  output logic       rfSwitch,
  output logic       txMixEn,
  output logic       rxMixEn,
  output logic [3:0] trSel,
  output logic       adcPwdn,
  output logic       chirpActive,
  output logic [5:0] chirpCount
);
  import chirp_seq_pkg::*;

  seqStrobe_t strobe;
  logic reqPulse;

  chirp_seq_ctl #(.TX_LEN(TX_LEN), .RX_LEN(RX_LEN)) uCtl (
    .clkTx(clkTx), .rstN(rstN), .reqPulse(reqPulse), .strobe(strobe)
  );

  chirp_seq_dp #(.CNT_W(6), .TR_N(4)) uDp (
    .clkCtl(clkCtl), .clkTx(clkTx), .rstN(rstN),
    .chirpReq(chirpReq), .mixMaster(mixMaster), .strobe(strobe),
    .reqPulse(reqPulse), .rfSwitch(rfSwitch), .txMixEn(txMixEn),
    .rxMixEn(rxMixEn), .trSel(trSel), .adcPwdn(adcPwdn),
    .chirpActive(chirpActive), .chirpCount(chirpCount)
  );
endmodule

// File: tb/chirp_interlock_test.sv
`timescale 1ns/1ps
module chirp_interlock_test;
  localparam int TXL = 40;
  localparam int RXL = 60;
  localparam int NV  = 5;
  // offset after a request (ns) and expected phase: 0 idle, 1 transmit, 2 listen
  localparam int VEC_T [NV] = '{150, 300, 550, 800, 1100};
  localparam int VEC_P [NV] = '{1, 1, 2, 2, 0};

  logic clkCtl = 1'b0, clkTx = 1'b0, rstN = 1'b0;
  logic chirpReq = 1'b0, mixMaster = 1'b1;
  logic rfSwitch, txMixEn, rxMixEn, adcPwdn, chirpActive;
  logic [3:0] trSel;
  logic [5:0] chirpCount;

  always #5 clkCtl = ~clkCtl;
  always #4 clkTx = ~clkTx;

  chirp_interlock #(.TX_LEN(TXL), .RX_LEN(RXL)) uut (
    .clkCtl(clkCtl), .clkTx(clkTx), .rstN(rstN), .chirpReq(chirpReq),
    .mixMaster(mixMaster), .rfSwitch(rfSwitch), .txMixEn(txMixEn),
    .rxMixEn(rxMixEn), .trSel(trSel), .adcPwdn(adcPwdn),
    .chirpActive(chirpActive), .chirpCount(chirpCount)
  );

  int checks = 0, fails = 0;
  int bothOn = 0, trBad = 0, pwdnOn = 0;
  int expCount = 0;

  always @(negedge clkTx) if (rstN) begin
    if (txMixEn && rxMixEn) bothOn++;
    if (trSel != 4'b0000 && trSel != 4'b1111) trBad++;
    if (adcPwdn) pwdnOn++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {rfSwitch, txMixEn, rxMixEn, trSel, chirpActive}
  function automatic int outsFor(input int ph, input logic en);
    case (ph)
      1: return {1'b1, en, 1'b0, 4'b1111, 1'b1};
      2: return {1'b0, 1'b0, en, 4'b0000, 1'b0};
      default: return 0;
    endcase
  endfunction

  function automatic int outsNow();
    return {rfSwitch, txMixEn, rxMixEn, trSel, chirpActive};
  endfunction

  task automatic request();
    @(posedge clkCtl); #3;
    chirpReq = ~chirpReq;
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clkCtl);
    #2;
    chk("R1 outputs", outsNow(), 0);
    chk("R1 adcPwdn", int'(adcPwdn), 0);
    chk("R1 count", int'(chirpCount), 0);
    rstN = 1'b1;
    repeat (5) @(posedge clkCtl);
    #2;
    chk("R1 idle after release", outsNow(), 0);

    // table: one request per row, alternating polarity (R2, R5)
    for (int v = 0; v < NV; v++) begin
      request();
      #(VEC_T[v]);
      @(negedge clkTx);
      chk("R5 phase outputs", outsNow(), outsFor(VEC_P[v], 1'b1));
      #(1400 - VEC_T[v]);
      expCount++;
      chk("R2 one sequence per edge", int'(chirpCount), expCount);
    end

    // R4: master enable dropped in the transmit window
    request();
    #150; @(negedge clkTx);
    chk("R4 tx mixer on before drop", int'(txMixEn), 1);
    @(posedge clkCtl); #2;
    mixMaster = 1'b0;
    repeat (12) @(posedge clkCtl);
    #2;
    chk("R4 mixers off within 12", int'({txMixEn, rxMixEn}), 0);
    chk("R4 rf switch still on", int'(rfSwitch), 1);
    #350; @(negedge clkTx);
    chk("R4 listen without rx mixer", outsNow(), outsFor(2, 1'b0));
    #900;
    mixMaster = 1'b1;
    expCount++;
    chk("R4 sequence completed", int'(chirpCount), expCount);

    // R9: two requests 500 ns apart
    request();
    #500;
    chirpReq = ~chirpReq;
    #2300;
    expCount += 2;
    chk("R9 both delivered", int'(chirpCount), expCount);

    // R8: one queued, one dropped
    request();
    #100; chirpReq = ~chirpReq;
    #100; chirpReq = ~chirpReq;
    #2400;
    expCount += 2;
    chk("R8 queue one drop one", int'(chirpCount), expCount);

    // R7: run up to the wrap
    while (expCount < 64) begin
      request();
      #1300;
      expCount++;
    end
    chk("R7 wrap to zero", int'(chirpCount), 0);
    request();
    #1300;
    chk("R7 count after wrap", int'(chirpCount), 1);

    chk("R3 mixers never together", bothOn, 0);
    chk("R6 trSel bits equal", trBad, 0);
    chk("R6 adcPwdn low", pwdnOn, 0);

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule